// File: doc/BRIEF.md
# Local Alignment Score Engine

This block computes the best local alignment score between two short nucleotide sequences with a linear gap penalty. A host loads symbols for sequence A and sequence B through a small write port. It sets a signed score for equal symbols, a signed score for unequal symbols and an unsigned gap penalty. It then supplies the two lengths and pulses `start`.

The engine fills the dynamic-programming score matrix in row-major order at one cell per clock. Each cell depends on three neighbours. The upper neighbour comes from a line buffer indexed by column. The diagonal neighbour comes from a register that holds the upper value seen one column earlier. The left neighbour comes from a register that holds the cell just produced. The full matrix is never stored.

A running maximum tracks the best cell and its 1-based row and column. When the run ends, `done` pulses for one cycle, and the score and position stay on the outputs until the next accepted start.

Top module: `sw_scorer`

## Requirements
- R1: Symbols are 2-bit codes, and any two distinct codes count as a mismatch. A write with `wr_sel`=0 stores sequence A and `wr_sel`=1 stores sequence B. Write address k (0-based) supplies the symbol at matrix row or column k+1.
- R2: For 1≤i≤M and 1≤j≤N, cell H(i,j) is the largest of four values: 0, H(i-1,j-1)+sim, H(i-1,j)-gap and H(i,j-1)-gap. Here sim is `match_sc` when A(i) equals B(j) and `mismatch_sc` otherwise, and both scores are signed.
- R3: Row 0 and column 0 are zero, and no cell score is ever negative.
- R4: A cell score that would exceed 2^SCORE_W-1 is clamped to 2^SCORE_W-1 and does not wrap.
- R5: `best_score` is the maximum over all computed cells. `best_i` and `best_j` give that cell's row and column. If no cell is above zero, the score is 0 and the position is (0,0).
- R6: On a tie, the position reported is the first maximal cell in row-major order.
- R7: An accepted start with M,N≥1 raises `busy` on the next edge. `done` pulses for exactly one cycle, M·N+1 clock edges after the start edge, and `busy` is low while `done` is high.
- R8: A start with M=0 or N=0 pulses `done` on the next edge with score 0 and position (0,0), and `busy` never rises.
- R9: A `start` pulse while `busy` is high is ignored, and the run in progress finishes with its original lengths and timing.
- R10: While idle, the result outputs hold their values until the next accepted start.
- R11: After reset, `busy`, `done`, `best_score`, `best_i` and `best_j` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Symbol write strobe |
| wr_sel | input | 1 | 0 selects sequence A, 1 selects sequence B |
| wr_addr | input | AW | 0-based symbol index |
| wr_sym | input | 2 | Symbol code |
| match_sc | input | SC_W | Signed score for equal symbols |
| mismatch_sc | input | SC_W | Signed score for unequal symbols |
| gap_pen | input | PEN_W | Unsigned linear gap penalty |
| len_m | input | LW | Length of sequence A (rows) |
| len_n | input | LW | Length of sequence B (columns) |
| start | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| best_score | output | SCORE_W | Best local alignment score |
| best_i | output | LW | Row of the best cell |
| best_j | output | LW | Column of the best cell |

## Verification
The hardest situation to reach from the ports is score saturation, because with the default 16-bit score a 16×16 run cannot get anywhere near the limit. The bench therefore builds the block with a narrow score width. It then drives a directed run of two identical sequences with the largest match score and no gap penalty, which pushes the diagonal chain past the ceiling. Ties are the other hard case. They are produced by a directed pair of sequences whose two equal maxima sit in different rows, and also by many random runs that use small score values. The results of these runs are compared with a reference matrix computed in the bench.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int SYM_W = 2;
  typedef logic [SYM_W-1:0] sym_t;
  typedef enum logic [1:0] {SYM_A = 2'd0, SYM_C = 2'd1, SYM_G = 2'd2, SYM_T = 2'd3} base_e;
endpackage

// File: rtl/sw_seq_store.sv
module sw_seq_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  sw_pkg::sym_t   wdata,
  input  logic [AW-1:0]  raddr,
  output sw_pkg::sym_t   rdata
);
  sw_pkg::sym_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

  always_comb begin
    if (we) assert_store_range_R1: assert (int'(waddr) < DEPTH);
  end
endmodule

// File: rtl/sw_row_buf.sv
module sw_row_buf #(
  parameter int DEPTH = 17,
  parameter int AW    = 5,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] line_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) line_q[waddr] <= wdata;
  end

  assign rdata = line_q[raddr];

  always_comb begin
    if (we) assert_line_range_R2: assert (int'(waddr) < DEPTH);
  end
endmodule

// File: rtl/sw_cell.sv
module sw_cell #(
  parameter int SCORE_W = 16,
  parameter int SC_W    = 8,
  parameter int PEN_W   = 8
) (
  input  sw_pkg::sym_t               sym_a,
  input  sw_pkg::sym_t               sym_b,
  input  logic [SCORE_W-1:0]         diag,
  input  logic [SCORE_W-1:0]         up,
  input  logic [SCORE_W-1:0]         left,
  input  logic signed [SC_W-1:0]     match_sc,
  input  logic signed [SC_W-1:0]     mismatch_sc,
  input  logic [PEN_W-1:0]           gap_pen,
  output logic [SCORE_W-1:0]         h
);
  localparam int EW = ((SCORE_W > PEN_W) ? SCORE_W : PEN_W) + 2;
  localparam logic signed [EW-1:0] CEIL = EW'({SCORE_W{1'b1}});

  logic signed [SC_W-1:0] sim;
  logic signed [EW-1:0]   sim_ext, gap_ext, diag_t, up_t, left_t, pick;

  always_comb begin
    sim     = (sym_a == sym_b) ? match_sc : mismatch_sc;
    sim_ext = EW'(sim);
    gap_ext = $signed(EW'(gap_pen));
    diag_t  = $signed(EW'(diag)) + sim_ext;
    up_t    = $signed(EW'(up)) - gap_ext;
    left_t  = $signed(EW'(left)) - gap_ext;
    pick    = '0;
    if (diag_t > pick) pick = diag_t;
    if (up_t   > pick) pick = up_t;
    if (left_t > pick) pick = left_t;
    if (pick > CEIL)   pick = CEIL;
    h = pick[SCORE_W-1:0];
  end
endmodule

// File: rtl/sw_scorer.sv
module sw_scorer #(
  parameter int MAX_LEN = 16,
  parameter int SCORE_W = 16,
  parameter int SC_W    = 8,
  parameter int PEN_W   = 8,
  localparam int AW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [AW-1:0]          wr_addr,
  input  logic [1:0]             wr_sym,
  input  logic signed [SC_W-1:0] match_sc,
  input  logic signed [SC_W-1:0] mismatch_sc,
  input  logic [PEN_W-1:0]       gap_pen,
  input  logic [LW-1:0]          len_m,
  input  logic [LW-1:0]          len_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [SCORE_W-1:0]     best_score,
  output logic [LW-1:0]          best_i,
  output logic [LW-1:0]          best_j
);
  localparam logic [LW-1:0] ONE = LW'(1);

  // run state
  logic               run_q, run_d, done_q, done_d;
  logic [LW-1:0]      i_q, i_d, j_q, j_d, m_q, m_d, n_q, n_d;
  logic [SCORE_W-1:0] diag_q, diag_d, left_q, left_d;
  logic [SCORE_W-1:0] best_q, best_d;
  logic [LW-1:0]      bi_q, bi_d, bj_q, bj_d;

  // datapath
  sw_pkg::sym_t       sym_a, sym_b;
  logic [SCORE_W-1:0] line_rd, up_v, diag_v, left_v, cell_h;
  logic               last_col, last_cell, line_we;

  sw_seq_store #(.DEPTH(MAX_LEN), .AW(AW)) u_seq_a (
    .clk(clk), .we(wr_en && !wr_sel), .waddr(wr_addr), .wdata(wr_sym),
    .raddr(AW'(i_q - ONE)), .rdata(sym_a));

  sw_seq_store #(.DEPTH(MAX_LEN), .AW(AW)) u_seq_b (
    .clk(clk), .we(wr_en && wr_sel), .waddr(wr_addr), .wdata(wr_sym),
    .raddr(AW'(j_q - ONE)), .rdata(sym_b));

  sw_row_buf #(.DEPTH(MAX_LEN + 1), .AW(LW), .W(SCORE_W)) u_line (
    .clk(clk), .we(line_we), .waddr(j_q), .wdata(cell_h),
    .raddr(j_q), .rdata(line_rd));

  sw_cell #(.SCORE_W(SCORE_W), .SC_W(SC_W), .PEN_W(PEN_W)) u_cell (
    .sym_a(sym_a), .sym_b(sym_b), .diag(diag_v), .up(up_v), .left(left_v),
    .match_sc(match_sc), .mismatch_sc(mismatch_sc), .gap_pen(gap_pen),
    .h(cell_h));

  // boundary row/column forced to zero
  always_comb begin
    up_v      = (i_q == ONE) ? '0 : line_rd;
    diag_v    = (j_q == ONE) ? '0 : diag_q;
    left_v    = (j_q == ONE) ? '0 : left_q;
    last_col  = (j_q == n_q);
    last_cell = last_col && (i_q == m_q);
    line_we   = run_q;
  end

  // next state
  always_comb begin
    run_d  = run_q;
    done_d = 1'b0;
    i_d    = i_q;
    j_d    = j_q;
    m_d    = m_q;
    n_d    = n_q;
    diag_d = diag_q;
    left_d = left_q;
    best_d = best_q;
    bi_d   = bi_q;
    bj_d   = bj_q;
    if (!run_q) begin
      if (start) begin
        best_d = '0;
        bi_d   = '0;
        bj_d   = '0;
        if (len_m == '0 || len_n == '0) begin
          done_d = 1'b1;
        end else begin
          run_d = 1'b1;
          i_d   = ONE;
          j_d   = ONE;
          m_d   = len_m;
          n_d   = len_n;
        end
      end
    end else begin
      diag_d = up_v;
      left_d = cell_h;
      if (cell_h > best_q) begin
        best_d = cell_h;
        bi_d   = i_q;
        bj_d   = j_q;
      end
      if (last_cell) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else if (last_col) begin
        j_d = ONE;
        i_d = i_q + ONE;
      end else begin
        j_d = j_q + ONE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      i_q    <= ONE;
      j_q    <= ONE;
      m_q    <= '0;
      n_q    <= '0;
      diag_q <= '0;
      left_q <= '0;
      best_q <= '0;
      bi_q   <= '0;
      bj_q   <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (run_q || start) begin
        i_q <= i_d;
        j_q <= j_d;
        m_q <= m_d;
        n_q <= n_d;
      end
      if (run_q) begin
        diag_q <= diag_d;
        left_q <= left_d;
      end
      best_q <= best_d;
      bi_q   <= bi_d;
      bj_q   <= bj_d;
    end
  end

  assign busy       = run_q;
  assign done       = done_q;
  assign best_score = best_q;
  assign best_i     = bi_q;
  assign best_j     = bj_q;

  // checks
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_best_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_score >= $past(best_score)));
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (len_m == '0 || len_n == '0)) |=> (done && !busy && best_score == '0));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(best_score));
  assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_i <= m_q && best_j <= n_q));
endmodule

// File: tb/sw_scorer_tb.sv
module sw_scorer_tb;
  localparam int ML = 16;
  localparam int SW = 10;
  localparam int AW = $clog2(ML);
  localparam int LW = $clog2(ML + 1);
  localparam int CEIL = (1 << SW) - 1;

  logic clk, rst_n, wr_en, wr_sel, start, busy, done;
  logic [AW-1:0] wr_addr;
  logic [1:0] wr_sym;
  logic signed [7:0] match_sc, mismatch_sc;
  logic [7:0] gap_pen;
  logic [LW-1:0] len_m, len_n, best_i, best_j;
  logic [SW-1:0] best_score;

  int checks = 0, errors = 0, cyc = 0;
  int sa [ML];
  int sb [ML];
  int ex_s, ex_i, ex_j;

  sw_scorer #(.MAX_LEN(ML), .SCORE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_sym(wr_sym), .match_sc(match_sc), .mismatch_sc(mismatch_sc), .gap_pen(gap_pen),
    .len_m(len_m), .len_n(len_n), .start(start), .busy(busy), .done(done),
    .best_score(best_score), .best_i(best_i), .best_j(best_j));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic void model(int m, int n, int mt, int mm, int g);
    int h [ML+1][ML+1];
    int v, s;
    ex_s = 0; ex_i = 0; ex_j = 0;
    for (int i = 0; i <= ML; i++) for (int j = 0; j <= ML; j++) h[i][j] = 0;
    for (int i = 1; i <= m; i++)
      for (int j = 1; j <= n; j++) begin
        s = (sa[i-1] == sb[j-1]) ? mt : mm;
        v = 0;
        if (h[i-1][j-1] + s > v) v = h[i-1][j-1] + s;
        if (h[i-1][j] - g > v) v = h[i-1][j] - g;
        if (h[i][j-1] - g > v) v = h[i][j-1] - g;
        if (v > CEIL) v = CEIL;
        h[i][j] = v;
        if (v > ex_s) begin ex_s = v; ex_i = i; ex_j = j; end
      end
  endfunction

  task automatic load(int m, int n);
    for (int k = 0; k < m; k++) begin
      @(negedge clk); wr_en = 1; wr_sel = 0; wr_addr = AW'(k); wr_sym = 2'(sa[k]);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk); wr_en = 1; wr_sel = 1; wr_addr = AW'(k); wr_sym = 2'(sb[k]);
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(string tag, int m, int n, int mt, int mm, int g, bit poke);
    int cnt;
    match_sc = 8'(mt); mismatch_sc = 8'(mm); gap_pen = 8'(g);
    len_m = LW'(m); len_n = LW'(n);
    model(m, n, mt, mm, g);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cnt = 1;
    if (m > 0 && n > 0) chk({tag, " R7 busy"}, int'(busy), 1);
    while (!done && cnt < 2000) begin
      if (poke && cnt == 3) begin
        start = 1; len_m = LW'(1); len_n = LW'(1);   // R9 ignored while busy
      end else start = 0;
      @(negedge clk); cnt++;
    end
    start = 0;
    chk({tag, " R7 latency"}, cnt, (m == 0 || n == 0) ? 1 : m * n + 1);
    chk({tag, " R7 busy low at done"}, int'(busy), 0);
    chk({tag, " R5 score"}, int'(best_score), ex_s);
    chk({tag, " R6 row"}, int'(best_i), ex_i);
    chk({tag, " R6 col"}, int'(best_j), ex_j);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, int'(done), 0);
    repeat (2) @(negedge clk);
    chk({tag, " R10 hold"}, int'(best_score), ex_s);
  endtask

  initial begin
    int m, n, seed;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_addr = '0; wr_sym = '0; start = 0;
    match_sc = 0; mismatch_sc = 0; gap_pen = 0; len_m = '0; len_n = '0;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 score", int'(best_score), 0);
    chk("R11 pos", int'(best_i) + int'(best_j), 0);

    // R8 zero lengths
    run("m0", 0, 5, 2, -1, 1, 0);
    run("n0", 4, 0, 2, -1, 1, 0);

    // R6 tie: A="AC", B="CA", max 2 at (1,2) and (2,1)
    sa[0] = 0; sa[1] = 1; sb[0] = 1; sb[1] = 0;
    load(2, 2);
    run("tie", 2, 2, 2, -3, 10, 0);

    // R3 all mismatches: floor at zero, position (0,0)
    for (int k = 0; k < ML; k++) begin sa[k] = 0; sb[k] = 3; end
    load(ML, ML);
    run("floor", ML, ML, 5, -4, 2, 0);

    // R4 saturation: identical sequences, max match, no gap
    for (int k = 0; k < ML; k++) begin sa[k] = k % 4; sb[k] = k % 4; end
    load(ML, ML);
    run("sat", ML, ML, 127, -128, 0, 0);

    // R9 start while busy
    for (int k = 0; k < ML; k++) begin sa[k] = $urandom % 4; sb[k] = $urandom % 4; end
    load(ML, ML);
    run("poke", 6, 7, 3, -2, 1, 1);

    // R1 R2 random
    for (int t = 0; t < 60; t++) begin
      m = 1 + $urandom % ML; n = 1 + $urandom % ML;
      for (int k = 0; k < ML; k++) begin sa[k] = $urandom % 4; sb[k] = $urandom % 4; end
      load(m, n);
      run("rand R2", m, n, 1 + $urandom % 6, -int'($urandom % 6), $urandom % 5, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule